// File: doc/BRIEF.md
# Burst-of-two double-data-rate SRAM device model

This block is a synthesizable model of the device side of a synchronous SRAM. Each command moves a pair of words, which a real part would transfer on the two halves of one clock period. Everything here runs in a single clock domain, so each data bus is split into two lanes per cycle. Beat 0 is the word for the first half-cycle and beat 1 is the word for the second.

A command is issued by pulling the active-low load strobe low. The read/write select then chooses the direction. The address gives the word for beat 0. Beat 1 always uses the other word of the same aligned pair, so a burst may start on an odd word and wrap within its pair. Writes take both beats and a separate active-low byte-lane mask for each beat in the command cycle. Reads return both beats after a fixed, parameterized latency, together with a valid flag.

Top module: `b2_sram`

## Requirements
- R1: While rst_ni is low, and after reset until the first read command has reached its latency, rvalid_o is 0.
- R2: A read command (ld_ni=0, rw_i=1) sampled at a rising edge raises rvalid_o for exactly one cycle, RD_LAT cycles later. In that cycle rdata0_o holds the word at addr_i and rdata1_o holds the word at addr_i with bit 0 inverted. rvalid_o is 0 in cycles that match no read.
- R3: A write command (ld_ni=0, rw_i=0) stores wdata0_i at addr_i and wdata1_i at addr_i with bit 0 inverted, both at the same edge.
- R4: Bit 0 of addr_i picks the start word of the pair. An odd start puts beat 0 at the odd word and beat 1 at the even word below it, and the upper address bits stay the same.
- R5: Bit l of bw0_ni (beat 0) or bw1_ni (beat 1) is active low. It gates data bits 9l+8..9l of that beat. A masked lane leaves the stored bits unchanged, and the two beats are masked independently.
- R6: While ld_ni is 1, addr_i, rw_i, the write data and the masks are ignored. No word changes and no read is issued.
- R7: A read issued in the cycle right after a write to the same pair returns the newly written bytes, and masked bytes return their previous contents.
- R8: Reads issued on consecutive cycles each produce their own valid beat pair, in order, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the control state |
| ld_ni | input | 1 | Active-low load strobe that defines a command |
| rw_i | input | 1 | Direction when loaded: 1 read, 0 write |
| addr_i | input | ADDR_W | Word address of beat 0 |
| wdata0_i | input | DATA_W | Write data, beat 0 |
| wdata1_i | input | DATA_W | Write data, beat 1 |
| bw0_ni | input | DATA_W/9 | Active-low byte-lane write enables, beat 0 |
| bw1_ni | input | DATA_W/9 | Active-low byte-lane write enables, beat 1 |
| rdata0_o | output | DATA_W | Read data, beat 0 |
| rdata1_o | output | DATA_W | Read data, beat 1 |
| rvalid_o | output | 1 | High in the cycle the read beats are valid |

## Verification
Full-mask writes fill the array first, and reads from even start words then check the basic pairing of the two beats. Reads and writes from odd start words show whether the beat order is swapped and the pair wraps, or whether the neighbouring pair is touched by mistake. Partial masks that differ between the two beats, each followed at once by a read of the same pair, separate per-beat masking from shared masking. They also show whether the array is updated before the next read. Deselected cycles carrying junk, back-to-back reads and a long random mix check that ignored inputs stay ignored and that the valid flag keeps step with each read.

// File: rtl/b2_pkg.sv
package b2_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } cmd_e;
endpackage

// File: rtl/b2_decode.sv
module b2_decode
  import b2_pkg::*;
(
  input  logic ld_ni,
  input  logic rw_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (ld_ni)     cmd_o = CMD_NOP;
    else if (rw_i) cmd_o = CMD_RD;
    else           cmd_o = CMD_WR;
  end
endmodule

// File: rtl/b2_bank.sv
module b2_bank
  import b2_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [DATA_W/LANE_W-1:0] we_i,
  input  logic [DATA_W-1:0]        wd_i,
  input  logic                     re_i,
  output logic [DATA_W-1:0]        q_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i[l]) mem[idx_i][l*LANE_W +: LANE_W] <= wd_i[l*LANE_W +: LANE_W];
    end
    if (re_i) q_o <= mem[idx_i];
  end

  // R2/R3: one command per cycle, so a bank never reads and writes together
  a_r3_rd_wr_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |-> (we_i == '0));
endmodule

// File: rtl/b2_rd_pipe.sv
module b2_rd_pipe #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned RD_LAT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              odd_i,
  input  logic [DATA_W-1:0] q_even_i,
  input  logic [DATA_W-1:0] q_odd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] beat0_o,
  output logic [DATA_W-1:0] beat1_o
);
  logic              v0_q;
  logic              odd_q;
  logic [DATA_W-1:0] b0_s0;
  logic [DATA_W-1:0] b1_s0;

  // stage 0 lines up with the bank read registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      v0_q <= rd_i;
      if (rd_i) odd_q <= odd_i;
    end
  end

  always_comb begin
    b0_s0 = odd_q ? q_odd_i  : q_even_i;
    b1_s0 = odd_q ? q_even_i : q_odd_i;
  end

  generate
    if (RD_LAT > 1) begin : g_dly
      localparam int unsigned N = RD_LAT - 1;
      logic              v_d  [N];
      logic [DATA_W-1:0] b0_d [N];
      logic [DATA_W-1:0] b1_d [N];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < N; k++) begin
            v_d[k]  <= 1'b0;
            b0_d[k] <= '0;
            b1_d[k] <= '0;
          end
        end else begin
          v_d[0]  <= v0_q;
          b0_d[0] <= b0_s0;
          b1_d[0] <= b1_s0;
          for (int k = 1; k < N; k++) begin
            v_d[k]  <= v_d[k-1];
            b0_d[k] <= b0_d[k-1];
            b1_d[k] <= b1_d[k-1];
          end
        end
      end

      assign valid_o = v_d[N-1];
      assign beat0_o = b0_d[N-1];
      assign beat1_o = b1_d[N-1];
    end else begin : g_direct
      assign valid_o = v0_q;
      assign beat0_o = b0_s0;
      assign beat1_o = b1_s0;
    end
  endgenerate
endmodule

// File: rtl/b2_sram.sv
module b2_sram
  import b2_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned RD_LAT = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_ni,
  input  logic                     rw_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata0_i,
  input  logic [DATA_W-1:0]        wdata1_i,
  input  logic [DATA_W/LANE_W-1:0] bw0_ni,
  input  logic [DATA_W/LANE_W-1:0] bw1_ni,
  output logic [DATA_W-1:0]        rdata0_o,
  output logic [DATA_W-1:0]        rdata1_o,
  output logic                     rvalid_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned IDX_W = ADDR_W - 1;
  localparam int unsigned CNT_W = $clog2(RD_LAT + 2);

  cmd_e              cmd;
  logic              odd;
  logic [IDX_W-1:0]  idx;
  logic              rd;
  logic [DATA_W-1:0] wd_even, wd_odd;
  logic [LANES-1:0]  mk_even, mk_odd;
  logic [LANES-1:0]  we_even, we_odd;
  logic [DATA_W-1:0] q_even, q_odd;

  b2_decode u_dec (
    .ld_ni (ld_ni),
    .rw_i  (rw_i),
    .cmd_o (cmd)
  );

  assign odd = addr_i[0];
  assign idx = addr_i[ADDR_W-1:1];
  assign rd  = (cmd == CMD_RD);

  // beat 0 lands on the start word, beat 1 on its partner in the pair
  always_comb begin
    wd_even = odd ? wdata1_i : wdata0_i;
    wd_odd  = odd ? wdata0_i : wdata1_i;
    mk_even = odd ? bw1_ni   : bw0_ni;
    mk_odd  = odd ? bw0_ni   : bw1_ni;
    we_even = (cmd == CMD_WR) ? ~mk_even : '0;
    we_odd  = (cmd == CMD_WR) ? ~mk_odd  : '0;
  end

  b2_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank_even (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .we_i   (we_even),
    .wd_i   (wd_even),
    .re_i   (rd),
    .q_o    (q_even)
  );

  b2_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank_odd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx),
    .we_i   (we_odd),
    .wd_i   (wd_odd),
    .re_i   (rd),
    .q_o    (q_odd)
  );

  b2_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd),
    .odd_i    (odd),
    .q_even_i (q_even),
    .q_odd_i  (q_odd),
    .valid_o  (rvalid_o),
    .beat0_o  (rdata0_o),
    .beat1_o  (rdata1_o)
  );

  // reads in flight, used only by the checks below
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(rd) - CNT_W'(rvalid_o);
  end

  a_r2_valid_has_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (inflight_q != '0));

  a_r8_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(RD_LAT));

  a_r6_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |-> (!rd && we_even == '0 && we_odd == '0));

  a_r5_full_mask_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&bw0_ni) && (&bw1_ni)) |-> (we_even == '0 && we_odd == '0));
endmodule

// File: tb/sim_b2_sram.sv
module sim_b2_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 36;
  localparam int AW  = 6;
  localparam int LAT = 1;
  localparam int NL  = DW / 9;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_n = 1'b1;
  logic          rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic [NL-1:0] bw0 = '1, bw1 = '1;
  logic [DW-1:0] rd0, rd1;
  logic          rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  b2_sram #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_ni(ld_n), .rw_i(rw), .addr_i(addr),
    .wdata0_i(wd0), .wdata1_i(wd1), .bw0_ni(bw0), .bw1_ni(bw1),
    .rdata0_o(rd0), .rdata1_o(rd1), .rvalid_o(rv)
  );

  typedef struct {
    int            due;
    logic [DW-1:0] d0;
    logic [DW-1:0] d1;
    string         tag;
  } exp_t;

  logic [DW-1:0] ref_mem [NW];
  exp_t          expq [$];
  int            cyc = 0;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 0;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_out();
    if (expq.size() > 0 && expq[0].due == cyc) begin
      chk({expq[0].tag, " rvalid"}, DW'(rv), DW'(1));
      chk({expq[0].tag, " beat0"}, rd0, expq[0].d0);
      chk({expq[0].tag, " beat1"}, rd1, expq[0].d1);
      void'(expq.pop_front());
    end else begin
      chk("R2 idle rvalid", DW'(rv), DW'(0));
    end
  endtask

  // one cycle: check outputs of the last edge, then drive the next command
  task automatic cmd(input logic l, input logic r, input int a,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input logic [NL-1:0] m0, input logic [NL-1:0] m1,
                     input string tag);
    exp_t e;
    int   b;
    @(negedge clk);
    check_out();
    ld_n = l; rw = r; addr = AW'(a);
    wd0 = d0; wd1 = d1; bw0 = m0; bw1 = m1;
    b = a ^ 1;
    if (!l && !r) begin
      for (int k = 0; k < NL; k++) begin
        if (!m0[k]) ref_mem[a][k*9 +: 9] = d0[k*9 +: 9];
        if (!m1[k]) ref_mem[b][k*9 +: 9] = d1[k*9 +: 9];
      end
    end else if (!l && r) begin
      e.due = cyc + LAT;
      e.d0  = ref_mem[a];
      e.d1  = ref_mem[b];
      e.tag = tag;
      expq.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(1'b1, 1'b0, 0, '0, '0, '1, '1, "R6");
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom(), $urandom()});
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 rvalid in reset", DW'(rv), DW'(0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rvalid after reset", DW'(rv), DW'(0));

    // R3: fill every pair with full masks from even starts
    for (int i = 0; i < NW; i += 2) cmd(1'b0, 1'b0, i, rnd(), rnd(), '0, '0, "R3");
    // R2: read back from even starts
    for (int i = 0; i < NW; i += 2) cmd(1'b0, 1'b1, i, '0, '0, '1, '1, "R2");
    idle(2);
    // R4: odd start reads and writes wrap within the pair
    for (int i = 1; i < 16; i += 2) cmd(1'b0, 1'b1, i, '0, '0, '1, '1, "R4");
    cmd(1'b0, 1'b0, 7, rnd(), rnd(), '0, '0, "R4");
    idle(1);
    cmd(1'b0, 1'b1, 6, '0, '0, '1, '1, "R4");
    cmd(1'b0, 1'b1, 8, '0, '0, '1, '1, "R4");
    cmd(1'b0, 1'b1, 4, '0, '0, '1, '1, "R4");
    idle(2);
    // R5: different partial masks per beat
    cmd(1'b0, 1'b0, 20, rnd(), rnd(), 4'b1010, 4'b0110, "R5");
    idle(1);
    cmd(1'b0, 1'b1, 20, '0, '0, '1, '1, "R5");
    cmd(1'b0, 1'b0, 21, rnd(), rnd(), 4'b0011, 4'b1100, "R5");
    idle(1);
    cmd(1'b0, 1'b1, 21, '0, '0, '1, '1, "R5");
    idle(2);
    // R7: read in the cycle right after a write to the same pair
    cmd(1'b0, 1'b0, 30, rnd(), rnd(), 4'b0101, 4'b1001, "R7");
    cmd(1'b0, 1'b1, 31, '0, '0, '1, '1, "R7");
    cmd(1'b0, 1'b0, 33, rnd(), rnd(), 4'b1110, 4'b0111, "R7");
    cmd(1'b0, 1'b1, 32, '0, '0, '1, '1, "R7");
    idle(2);
    // R6: deselected cycles carrying junk change nothing and read nothing
    cmd(1'b1, 1'b0, 4, rnd(), rnd(), '0, '0, "R6");
    cmd(1'b1, 1'b1, 5, rnd(), rnd(), '0, '0, "R6");
    cmd(1'b1, 1'b0, 41, rnd(), rnd(), '0, '0, "R6");
    cmd(1'b0, 1'b1, 4, '0, '0, '1, '1, "R6");
    cmd(1'b0, 1'b1, 40, '0, '0, '1, '1, "R6");
    idle(2);
    // R8: back-to-back reads
    for (int i = 0; i < 12; i++) cmd(1'b0, 1'b1, (i * 5) % NW, '0, '0, '1, '1, "R8");
    idle(2);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom());
      cmd(((r & 3) == 0), r[2], (r >> 3) % NW, rnd(), rnd(),
          NL'($urandom()), NL'($urandom()), r[2] ? "R8" : "R5");
    end
    idle(LAT + 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired cyc=%0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule